// File: doc/BRIEF.md
# Dual-Thread In-Order Dispatch Queue

This block holds decoded operations waiting to issue on a two-wide in-order core that runs either one or two hardware threads. In single-thread mode all entries of one store form a single circular queue for thread 0. In two-thread mode the store is cut into two equal halves, and each thread owns one half as its own in-order queue. An external scoreboard drives one operand-ready bit per physical slot. Each cycle the block looks only at the oldest and second-oldest entry of each thread and presents up to two operations on two symmetric dispatch ports, together with the thread that each one belongs to.

Either port accepts any operation class, so the choice of port depends only on age and thread priority. A thread whose oldest entry is waiting for data gives both ports to the other thread. When both threads have a ready oldest entry, each thread gets one port, and a round-robin pointer decides which thread takes port 0. The dispatch ports carry no backpressure: an operation shown on a valid port leaves the queue at the next rising edge.

Top module: `dual_issue_queue`

## Requirements
- R1: With mode 0 (single-thread), only thread 0 is served. It can hold up to DEPTH operations, enq_ready[1] stays 0, and every dispatched operation carries thread ID 0.
- R2: With mode 1 (two-thread), each thread owns HALF = DEPTH/2 entries. Thread t only reads slot_ready bits in slots t*HALF to t*HALF+HALF-1, and an operation of one thread is never dispatched because of the other partition's readiness.
- R3: At most two operations dispatch per cycle. Port 1 is valid only when port 0 is valid.
- R4: Thread selection does not alternate by cycle. A thread with a ready oldest entry takes both ports whenever the other thread has no ready oldest entry.
- R5: When one thread's oldest entry is not ready, the ports go to ready operations of the other thread in that same cycle.
- R6: Within a thread, operations dispatch in enqueue order. A not-ready oldest entry blocks every younger entry of that thread.
- R7: Two operations of one thread dispatch together only when both the oldest and second-oldest entries are ready and the second-oldest was enqueued with enq_dep = 0. enq_dep = 1 marks an operation as dependent on the one before it in its thread. When paired, the oldest goes on port 0.
- R8: When both threads' oldest entries are ready, each thread dispatches exactly its oldest entry. The priority thread takes port 0. Priority is thread 0 after reset and flips after every such cycle.
- R9: enq_ready[t] is 0 while thread t holds its full level: DEPTH in mode 0, HALF in mode 1.
- R10: A change of mode_req is applied only at the first rising edge at which the queue is completely empty. While the change is pending, enq_ready is 0 for both threads and dual_mode keeps its old value.
- R11: Counting from reset or from the last mode switch, the k-th accepted operation of thread t sits in slot k mod DEPTH in mode 0, or in slot t*HALF + (k mod HALF) in mode 1. Dispatch outputs respond combinationally to slot_ready in the same cycle.
- R12: Synchronous active-high reset empties the queue, selects mode 0 and gives round-robin priority to thread 0. In the first cycle after reset no port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Requested mode: 0 single-thread, 1 two-thread |
| dual_mode | output | 1 | Mode currently in effect |
| enq_valid | input | 2 | Enqueue request, one bit per thread |
| enq_ready | output | 2 | Enqueue accept, one bit per thread |
| enq_data | input | 2*PW | Operation payload per thread |
| enq_dep | input | 2 | Per thread: operation depends on its predecessor |
| slot_ready | input | DEPTH | Operand-ready bit per physical slot, from the scoreboard |
| dsp_valid | output | 2 | Dispatch valid for port 0 and port 1 |
| dsp_data | output | 2*PW | Payload on each dispatch port |
| dsp_tid | output | 2 | Thread ID on each dispatch port |

## Verification
The bench sweeps every combination of readiness over the two head entries of both threads, crossed with the dependency flag of each second entry. This separates competition between threads, one thread taking both ports, a blocked pair and a stalled thread giving its ports away. Filling with enqueue offered on both threads shows the capacity in each mode. A stalled oldest entry with all younger entries ready tells in-order blocking apart from out-of-order pickup. A dependency flag placed mid-stream shows a pair being split. Back-to-back competing cycles expose the round-robin order. A mode request made while entries remain shows that the request is held until the queue drains.

// File: rtl/dual_issue_queue.sv
module dual_issue_queue #(
  parameter int DEPTH = 32,
  parameter int PW    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_req,
  output logic                 dual_mode,
  input  logic [1:0]           enq_valid,
  output logic [1:0]           enq_ready,
  input  logic [1:0][PW-1:0]   enq_data,
  input  logic [1:0]           enq_dep,
  input  logic [DEPTH-1:0]     slot_ready,
  output logic [1:0]           dsp_valid,
  output logic [1:0][PW-1:0]   dsp_data,
  output logic [1:0]           dsp_tid
);
  localparam int HALF = DEPTH / 2;
  localparam int IW   = $clog2(DEPTH);
  localparam int CW   = IW + 1;

  logic [PW-1:0]         mem [DEPTH];
  logic [DEPTH-1:0]      dep_q;
  logic [1:0][IW-1:0]    head, tail;
  logic [1:0][CW-1:0]    cnt;
  logic                  dual_q, rr_q;

  logic [CW-1:0]         cap;
  logic                  chg_pend, q_empty, both, first;
  logic [1:0][IW-1:0]    h0_idx, h1_idx;
  logic [1:0]            rdy0, rdy1, push;
  logic [1:0][1:0]       pop_n;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p, input logic d);
    logic [CW-1:0] lim;
    lim = d ? CW'(HALF) : CW'(DEPTH);
    return (CW'(p) + CW'(1) == lim) ? '0 : p + IW'(1);
  endfunction

  function automatic logic [IW-1:0] phys(input logic t, input logic [IW-1:0] p, input logic d);
    return (d && t) ? IW'(HALF) + p : p;
  endfunction

  assign cap       = dual_q ? CW'(HALF) : CW'(DEPTH);
  assign chg_pend  = mode_req != dual_q;
  assign q_empty   = cnt[0] == '0 && cnt[1] == '0;
  assign dual_mode = dual_q;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      h0_idx[t] = phys(t[0], head[t], dual_q);
      h1_idx[t] = phys(t[0], nxt(head[t], dual_q), dual_q);
      rdy0[t]   = cnt[t] != '0 && slot_ready[h0_idx[t]];
      rdy1[t]   = rdy0[t] && cnt[t] >= CW'(2) && slot_ready[h1_idx[t]] && !dep_q[h1_idx[t]];
      enq_ready[t] = !chg_pend && (t == 0 || dual_q) && cnt[t] != cap;
      push[t]   = enq_valid[t] && enq_ready[t];
    end
  end

  assign both  = rdy0[0] && rdy0[1];
  assign first = both ? rr_q : rdy0[1] && !rdy0[0];

  assign dsp_valid[0] = rdy0[0] || rdy0[1];
  assign dsp_tid[0]   = first;
  assign dsp_data[0]  = mem[h0_idx[first]];
  assign dsp_valid[1] = both || rdy1[first];
  assign dsp_tid[1]   = both ? !first : first;
  assign dsp_data[1]  = both ? mem[h0_idx[!first]] : mem[h1_idx[first]];

  always_comb begin
    for (int t = 0; t < 2; t++)
      pop_n[t] = {1'b0, dsp_valid[0] && dsp_tid[0] == t[0]}
               + {1'b0, dsp_valid[1] && dsp_tid[1] == t[0]};
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < 2; t++)
      if (push[t]) begin
        mem[phys(t[0], tail[t], dual_q)]   <= enq_data[t];
        dep_q[phys(t[0], tail[t], dual_q)] <= enq_dep[t];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      head   <= '0;
      tail   <= '0;
      dual_q <= 1'b0;
      rr_q   <= 1'b0;
    end else if (chg_pend && q_empty) begin
      dual_q <= mode_req;
      head   <= '0;
      tail   <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (push[t]) tail[t] <= nxt(tail[t], dual_q);
        if (pop_n[t] == 2'd2)      head[t] <= nxt(nxt(head[t], dual_q), dual_q);
        else if (pop_n[t] == 2'd1) head[t] <= nxt(head[t], dual_q);
        cnt[t] <= cnt[t] + CW'(push[t]) - CW'(pop_n[t]);
      end
      if (both) rr_q <= !rr_q;
    end
  end
endmodule

// File: rtl/dual_issue_queue_chk.sv
module dual_issue_queue_chk #(
  parameter int DEPTH = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       dual_mode,
  input logic [1:0] enq_valid,
  input logic [1:0] enq_ready,
  input logic [1:0] dsp_valid,
  input logic [1:0] dsp_tid
);
  localparam int HALF = DEPTH / 2;
  localparam int CW   = $clog2(DEPTH) + 1;

  logic [1:0][CW-1:0] occ;
  logic [1:0][1:0]    npop;
  logic               split, quiet;

  always_comb begin
    for (int t = 0; t < 2; t++)
      npop[t] = {1'b0, dsp_valid[0] && dsp_tid[0] == t[0]}
              + {1'b0, dsp_valid[1] && dsp_tid[1] == t[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else for (int t = 0; t < 2; t++)
      occ[t] <= occ[t] + CW'(enq_valid[t] && enq_ready[t]) - CW'(npop[t]);
  end

  assign split = dsp_valid == 2'b11 && dsp_tid[0] != dsp_tid[1];
  assign quiet = occ[0] == '0 && occ[1] == '0;

  AST_PORT1_AFTER_PORT0: assert property (@(posedge clk) disable iff (rst)
    dsp_valid[1] |-> dsp_valid[0]);  // R3
  AST_SINGLE_THREAD0: assert property (@(posedge clk) disable iff (rst)
    !dual_mode |-> !enq_ready[1] && !(dsp_valid[0] && dsp_tid[0]) && !(dsp_valid[1] && dsp_tid[1]));  // R1
  AST_DUAL_CAPACITY: assert property (@(posedge clk) disable iff (rst)
    dual_mode |-> occ[0] <= CW'(HALF) && occ[1] <= CW'(HALF));  // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (occ[0] == (dual_mode ? CW'(HALF) : CW'(DEPTH))) |-> !enq_ready[0]);  // R9
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    dsp_valid[0] |-> occ[dsp_tid[0]] != '0);  // R6
  AST_MODE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !$stable(dual_mode) |-> $past(quiet));  // R10
  AST_RR_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (split && $past(split)) |-> dsp_tid[0] != $past(dsp_tid[0]));  // R8
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dsp_valid == 2'b00 && !dual_mode);  // R12
endmodule

bind dual_issue_queue dual_issue_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .dual_mode(dual_mode), .enq_valid(enq_valid),
  .enq_ready(enq_ready), .dsp_valid(dsp_valid), .dsp_tid(dsp_tid)
);

// File: tb/tb_dual_issue_queue.sv
`timescale 1ns/1ps
module tb_dual_issue_queue;
  localparam int DEPTH = 8;
  localparam int PW    = 8;

  logic clk = 0, rst = 1, mode_req = 0;
  logic dual_mode;
  logic [1:0] enq_valid = 0, enq_ready, enq_dep = 0;
  logic [1:0][PW-1:0] enq_data = '0;
  logic [DEPTH-1:0] slot_ready = '0;
  logic [1:0] dsp_valid, dsp_tid;
  logic [1:0][PW-1:0] dsp_data;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_issue_queue #(.DEPTH(DEPTH), .PW(PW)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1; enq_valid = 0; slot_ready = '0; mode_req = 0;
    step(); step();
    rst = 0;
  endtask

  task automatic set_dual();
    mode_req = 1;
    step();
    chk(dual_mode == 1, "R10 switch on empty", dual_mode, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    int p;
    bit e2;
    do_reset();
    #1;
    // R12 / R1 reset state
    chk(enq_ready == 2'b01, "R12 enq_ready", enq_ready, 1);
    chk(dsp_valid == 2'b00, "R12 dsp_valid", dsp_valid, 0);
    chk(dual_mode == 0, "R12 mode", dual_mode, 0);

    // R9 / R1 single-mode fill, thread 1 also requesting
    acc = 0;
    for (int i = 0; i < 10; i++) begin
      enq_valid = 2'b11;
      enq_data[0] = PW'(acc); enq_data[1] = 8'hEE;
      enq_dep[0] = (acc == 3);
      #1;
      chk(enq_ready[1] == 0, "R1 thread1 ready", enq_ready[1], 0);
      if (enq_ready[0]) acc++;
      step();
    end
    enq_valid = 0; enq_dep = 0;
    chk(acc == DEPTH, "R9 single capacity", acc, DEPTH);

    // R6 stalled oldest blocks younger
    slot_ready = 8'hFE; #1;
    chk(dsp_valid == 2'b00, "R6 oldest blocks", dsp_valid, 0);

    // R6 R7 R11 in-order drain with dependency split at entry 3
    slot_ready = 8'hFF;
    p = 0;
    for (int c = 0; c < 8 && p < 8; c++) begin
      #1;
      e2 = (p + 1 < 8) && (p + 1 != 3);
      chk(dsp_valid[0] && dsp_tid[0] == 0 && dsp_data[0] == PW'(p), "R6 port0 order", dsp_data[0], p);
      chk(dsp_valid[1] == e2, "R7 pairing", dsp_valid[1], e2);
      if (e2) chk(dsp_data[1] == PW'(p + 1) && dsp_tid[1] == 0, "R7 port1 data", dsp_data[1], p + 1);
      p += 1 + int'(e2);
      step();
    end
    #1;
    chk(dsp_valid == 2'b00, "R3 drained", dsp_valid, 0);

    // R11 wraparound: next ops go to slots 0,1,2
    for (int k = 8; k < 11; k++) begin
      slot_ready = '0; enq_valid = 2'b01; enq_data[0] = PW'(k); step();
    end
    enq_valid = 0;
    slot_ready = 8'b0000_0110; #1;
    chk(dsp_valid == 2'b00, "R11 slot map stall", dsp_valid, 0);
    slot_ready = 8'b0000_0001; #1;
    chk(dsp_valid == 2'b01 && dsp_data[0] == 8, "R7 second not ready", dsp_valid, 1);
    step();
    slot_ready = 8'hFF; #1;
    chk(dsp_valid == 2'b11 && dsp_data[0] == 9 && dsp_data[1] == 10, "R11 wrap pair", dsp_data[1], 10);
    step();

    // R10 pending mode change
    slot_ready = '0; enq_valid = 2'b01; enq_data[0] = 8'd11; step();
    enq_valid = 0; mode_req = 1;
    step();
    chk(dual_mode == 0, "R10 held while busy", dual_mode, 0);
    chk(enq_ready == 2'b00, "R10 enqueue blocked", enq_ready, 0);
    slot_ready = 8'hFF; step();
    chk(dual_mode == 0, "R10 not before drain", dual_mode, 0);
    step();
    chk(dual_mode == 1, "R10 applied after drain", dual_mode, 1);
    chk(enq_ready == 2'b11, "R2 both ready", enq_ready, 3);

    // R9 R2 dual fill
    slot_ready = '0;
    begin
      int a0, a1;
      a0 = 0; a1 = 0;
      for (int i = 0; i < 6; i++) begin
        enq_valid = 2'b11;
        enq_data[0] = PW'(a0); enq_data[1] = PW'(64 + a1);
        #1;
        if (enq_ready[0]) a0++;
        if (enq_ready[1]) a1++;
        step();
      end
      enq_valid = 0;
      chk(a0 == DEPTH / 2, "R9 dual cap t0", a0, DEPTH / 2);
      chk(a1 == DEPTH / 2, "R9 dual cap t1", a1, DEPTH / 2);
    end

    // R5 R4 R2 only thread 1 partition ready
    slot_ready = 8'hF0;
    for (int c = 0; c < 2; c++) begin
      #1;
      chk(dsp_valid == 2'b11 && dsp_tid == 2'b11, "R4 thread1 both ports", dsp_tid, 3);
      chk(dsp_data[0] == PW'(64 + 2 * c) && dsp_data[1] == PW'(65 + 2 * c), "R5 thread1 data", dsp_data[0], 64 + 2 * c);
      step();
    end
    #1;
    chk(dsp_valid == 2'b00, "R2 partition isolation", dsp_valid, 0);
    slot_ready = 8'h0F;
    for (int c = 0; c < 2; c++) begin
      #1;
      chk(dsp_valid == 2'b11 && dsp_tid == 2'b00 && dsp_data[0] == PW'(2 * c), "R4 thread0 both ports", dsp_data[0], 2 * c);
      step();
    end

    // sweep of head readiness and dependency flags (R4 R5 R7 R8)
    for (int pat = 0; pat < 16; pat++) begin
      for (int dp = 0; dp < 4; dp++) begin
        logic [1:0] ev;
        logic et0, et1;
        int ed0, ed1;
        bit a0, a1, b0, b1;
        do_reset();
        set_dual();
        enq_valid = 2'b11; enq_dep = 2'b00;
        enq_data[0] = 8'd0; enq_data[1] = 8'd64; step();
        enq_dep = dp[1:0];
        enq_data[0] = 8'd1; enq_data[1] = 8'd65; step();
        enq_valid = 0; enq_dep = 0;
        slot_ready = {2'b00, pat[3:2], 2'b00, pat[1:0]};
        #1;
        a0 = pat[0]; a1 = pat[1] && !dp[0];
        b0 = pat[2]; b1 = pat[3] && !dp[1];
        et0 = 0; et1 = 0; ed0 = 0; ed1 = 0;
        if (a0 && b0) begin ev = 2'b11; et1 = 1; ed1 = 64; end
        else if (a0) begin ev = {a1, 1'b1}; ed1 = 1; end
        else if (b0) begin ev = {b1, 1'b1}; et0 = 1; et1 = 1; ed0 = 64; ed1 = 65; end
        else ev = 2'b00;
        chk(dsp_valid == ev, "R5 sweep valid", dsp_valid, ev);
        if (ev[0]) chk(dsp_tid[0] == et0 && dsp_data[0] == PW'(ed0), "R8 sweep port0", dsp_data[0], ed0);
        if (ev[1]) chk(dsp_tid[1] == et1 && dsp_data[1] == PW'(ed1), "R7 sweep port1", dsp_data[1], ed1);
      end
    end

    // R8 round-robin alternation
    do_reset();
    set_dual();
    for (int k = 0; k < 4; k++) begin
      enq_valid = 2'b11; enq_data[0] = PW'(k); enq_data[1] = PW'(64 + k); step();
    end
    enq_valid = 0;
    slot_ready = 8'hFF;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk(dsp_valid == 2'b11 && dsp_tid[0] == c[0] && dsp_tid[1] == !c[0], "R8 priority flip", dsp_tid[0], c[0]);
      chk(dsp_data[0] == PW'(c[0] * 64 + c), "R8 port0 data", dsp_data[0], c[0] * 64 + c);
      step();
    end

    // R12 reset mid-operation
    slot_ready = '0;
    enq_valid = 2'b11; step(); enq_valid = 0;
    mode_req = 0; rst = 1; step(); rst = 0;
    slot_ready = 8'hFF; #1;
    chk(dsp_valid == 2'b00 && dual_mode == 0, "R12 reset clears", dsp_valid, 0);
    chk(enq_ready == 2'b01, "R12 single after reset", enq_ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule